// File: doc/BRIEF.md
# Delayed Write Retire Buffer

This block holds one pending write between a memory channel's column command stream and a row buffer. A write command addressed to this device captures a 128-bit data unit of 16 bytes, a per-byte enable mask, a 5-bit bank number and a 6-bit column index into a single entry. The row buffer does not receive the entry at once. The block writes it out (retires it) during a later column slot, and only in a slot where retiring is permitted.

Every column slot that is not a read to this device may retire the held entry. A read to this device leaves the entry in place, so the internal data path stays free for the read. A write to this device that finds the buffer occupied retires the old entry and captures the new one at the same clock edge. A retire appears as a one-cycle strobe, registered one cycle after the slot, carrying the stored bank, column, data and mask.

The control is a two-state machine. `ST_EMPTY` means no entry is held. `ST_HELD` means one entry is waiting. The transitions are:
- **capture**: `ST_EMPTY` to `ST_HELD`, on a write to this device.
- **swap**: `ST_HELD` to `ST_HELD`, on a write to this device. The old entry retires and the new one is captured.
- **stall**: `ST_HELD` to `ST_HELD`, on a read to this device, or on a cycle with no slot.
- **drain**: `ST_HELD` to `ST_EMPTY`, on any other slot.

Top module: `dwrb_top`

## Requirements
- R1: After reset, `buf_valid` and `ret_valid` are 0.
- R2: A slot with `col_op` = 2'b10 (write) and `col_dev` equal to `my_dev` captures bank, column, data and mask. `buf_valid` is 1 after that edge.
- R3: When `wr_masked` is 1, the stored mask equals `wr_mask`, where bit i enables byte i (data bits 8i+7..8i). When `wr_masked` is 0, the stored mask is all ones.
- R4: With the buffer occupied, a slot of any op whose `col_dev` differs from `my_dev` retires the entry. `ret_valid` is 1 in the next cycle, with the stored fields. The buffer becomes empty.
- R5: With the buffer occupied, a slot to this device with `col_op` = 2'b00 (no-op) or 2'b10 (write) retires the entry.
- R6: A slot to this device with `col_op` = 2'b01 (read) never retires. The entry and `buf_valid` are kept.
- R7: A write to this device while the buffer is occupied retires the old entry and holds the new one, with `buf_valid` staying 1.
- R8: A cycle with `col_valid` = 0 causes no retire and leaves `buf_valid` unchanged.
- R9: A write to another device does not fill an empty buffer.
- R10: No retire occurs while the buffer is empty.
- R11: `ret_bank`, `ret_addr`, `ret_data` and `ret_mask` hold their last retired values while `ret_valid` is 0. They are 0 after reset.
- R12: `col_op` = 2'b11 behaves exactly as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_dev | input | 5 | This device's identifier |
| col_valid | input | 1 | A column slot is present this cycle |
| col_op | input | 2 | 00 no-op, 01 read, 10 write, 11 treated as no-op |
| col_dev | input | 5 | Device targeted by the slot |
| col_bank | input | 5 | Bank of a write |
| col_addr | input | 6 | Column (data unit index) of a write |
| wr_data | input | 128 | Write data unit |
| wr_mask | input | 16 | Per-byte enables of a write |
| wr_masked | input | 1 | 1: use wr_mask, 0: write every byte |
| buf_valid | output | 1 | Buffer holds an entry |
| ret_valid | output | 1 | Retire strobe |
| ret_bank | output | 5 | Bank of the retired entry |
| ret_addr | output | 6 | Column of the retired entry |
| ret_data | output | 128 | Data of the retired entry |
| ret_mask | output | 16 | Byte mask of the retired entry |

## Verification
A wrong state bit shows within one cycle, in one of two ways. A retire strobe appears after a slot that should have been stalled, or `buf_valid` disagrees with the model on the very next edge. Corrupted entry storage stays hidden until the next retire, which then delivers the wrong bank, column, data or mask. For that reason every capture in the bench is followed within a few slots by a retire. A wrong retire decision against the read rule shows as a missing or extra strobe one cycle after the offending slot.

// File: rtl/dwrb_pkg.sv
package dwrb_pkg;

    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_RD   = 2'b01,
        OP_WR   = 2'b10,
        OP_RSVD = 2'b11
    } col_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } buf_state_e;

endpackage

// File: rtl/dwrb_slot_decode.sv
module dwrb_slot_decode
    import dwrb_pkg::*;
#(
    parameter int DEV_W = 5
) (
    input  logic             slot_valid,
    input  logic [1:0]       slot_op,
    input  logic [DEV_W-1:0] slot_dev,
    input  logic [DEV_W-1:0] self_dev,
    output logic             take_new,
    output logic             may_retire
);
    logic    hit;
    col_op_e op;

    always_comb begin
        op         = col_op_e'(slot_op);
        hit        = (slot_dev == self_dev);
        take_new   = slot_valid && hit && (op == OP_WR);
        may_retire = slot_valid && !(hit && (op == OP_RD));
    end
endmodule

// File: rtl/dwrb_mask_expand.sv
module dwrb_mask_expand #(
    parameter int LANES = 16
) (
    input  logic [LANES-1:0] lane_en_in,
    input  logic             use_mask,
    output logic [LANES-1:0] lane_en_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en_out[g] = use_mask ? lane_en_in[g] : 1'b1;
    end
endmodule

// File: rtl/dwrb_entry_store.sv
module dwrb_entry_store
    import dwrb_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int COL_W  = 6,
    parameter int LANES  = 16,
    localparam int DATA_W = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_new,
    input  logic              may_retire,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [COL_W-1:0]  in_col,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_mask,
    output logic              held,
    output logic              out_valid,
    output logic [BANK_W-1:0] out_bank,
    output logic [COL_W-1:0]  out_col,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_mask
);
    buf_state_e state_q, state_d;
    logic              drain_now;
    logic [BANK_W-1:0] e_bank;
    logic [COL_W-1:0]  e_col;
    logic [DATA_W-1:0] e_data;
    logic [LANES-1:0]  e_mask;

    always_comb begin
        state_d   = state_q;
        drain_now = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (take_new) state_d = ST_HELD;      // capture
            end
            ST_HELD: begin
                drain_now = may_retire;
                if (may_retire && !take_new) state_d = ST_EMPTY; // drain
                // swap and stall stay in ST_HELD
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_bank    <= '0;
            e_col     <= '0;
            e_data    <= '0;
            e_mask    <= '0;
            out_valid <= 1'b0;
            out_bank  <= '0;
            out_col   <= '0;
            out_data  <= '0;
            out_mask  <= '0;
        end else begin
            out_valid <= drain_now;
            if (drain_now) begin
                out_bank <= e_bank;
                out_col  <= e_col;
                out_data <= e_data;
                out_mask <= e_mask;
            end
            if (take_new) begin
                e_bank <= in_bank;
                e_col  <= in_col;
                e_data <= in_data;
                e_mask <= in_mask;
            end
        end
    end

    always_comb held = (state_q == ST_HELD);

    p_empty_no_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !held |=> !out_valid);
    p_take_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_new |=> held);
    p_hold_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_data) && $stable(out_mask) && $stable(out_bank) && $stable(out_col)));
endmodule

// File: rtl/dwrb_top.sv
module dwrb_top
    import dwrb_pkg::*;
#(
    parameter int DEV_W  = 5,
    parameter int BANK_W = 5,
    parameter int COL_W  = 6,
    parameter int LANES  = 16,
    localparam int DATA_W = LANES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  my_dev,
    input  logic              col_valid,
    input  logic [1:0]        col_op,
    input  logic [DEV_W-1:0]  col_dev,
    input  logic [BANK_W-1:0] col_bank,
    input  logic [COL_W-1:0]  col_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_mask,
    input  logic              wr_masked,
    output logic              buf_valid,
    output logic              ret_valid,
    output logic [BANK_W-1:0] ret_bank,
    output logic [COL_W-1:0]  ret_addr,
    output logic [DATA_W-1:0] ret_data,
    output logic [LANES-1:0]  ret_mask
);
    logic             take_new, may_retire;
    logic [LANES-1:0] eff_mask;

    dwrb_slot_decode #(.DEV_W(DEV_W)) u_dec (
        .slot_valid (col_valid),
        .slot_op    (col_op),
        .slot_dev   (col_dev),
        .self_dev   (my_dev),
        .take_new   (take_new),
        .may_retire (may_retire)
    );

    dwrb_mask_expand #(.LANES(LANES)) u_mask (
        .lane_en_in  (wr_mask),
        .use_mask    (wr_masked),
        .lane_en_out (eff_mask)
    );

    dwrb_entry_store #(.BANK_W(BANK_W), .COL_W(COL_W), .LANES(LANES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_new   (take_new),
        .may_retire (may_retire),
        .in_bank    (col_bank),
        .in_col     (col_addr),
        .in_data    (wr_data),
        .in_mask    (eff_mask),
        .held       (buf_valid),
        .out_valid  (ret_valid),
        .out_bank   (ret_bank),
        .out_col    (ret_addr),
        .out_data   (ret_data),
        .out_mask   (ret_mask)
    );

    p_own_read_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_op == 2'b01 && col_dev == my_dev) |=> !ret_valid);
    p_foreign_drains_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && col_valid && col_dev != my_dev) |=> ret_valid);
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |=> (!ret_valid && $stable(buf_valid)));
    p_swap_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && col_valid && col_op == 2'b10 && col_dev == my_dev) |=> (ret_valid && buf_valid));
endmodule

// File: tb/dwrb_top_test.sv
module dwrb_top_test;
    localparam logic [4:0] OWN = 5'h0B;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         col_valid = 1'b0;
    logic [1:0]   col_op = 2'b00;
    logic [4:0]   col_dev = 5'h00;
    logic [4:0]   col_bank = 5'h00;
    logic [5:0]   col_addr = 6'h00;
    logic [127:0] wr_data = '0;
    logic [15:0]  wr_mask = '0;
    logic         wr_masked = 1'b0;
    logic         buf_valid, ret_valid;
    logic [4:0]   ret_bank;
    logic [5:0]   ret_addr;
    logic [127:0] ret_data;
    logic [15:0]  ret_mask;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic         mv = 0;
    logic [4:0]   mb = '0;
    logic [5:0]   mc = '0;
    logic [127:0] md = '0;
    logic [15:0]  mm = '0;
    logic [4:0]   lb = '0;
    logic [5:0]   lc = '0;
    logic [127:0] ld = '0;
    logic [15:0]  lm = '0;
    int unsigned  seed = 32'h1357_9BDF;

    always #2 clk = ~clk;

    dwrb_top uut (
        .clk(clk), .rst_n(rst_n), .my_dev(OWN),
        .col_valid(col_valid), .col_op(col_op), .col_dev(col_dev),
        .col_bank(col_bank), .col_addr(col_addr), .wr_data(wr_data),
        .wr_mask(wr_mask), .wr_masked(wr_masked),
        .buf_valid(buf_valid), .ret_valid(ret_valid), .ret_bank(ret_bank),
        .ret_addr(ret_addr), .ret_data(ret_data), .ret_mask(ret_mask)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] mkdata(input int s);
        logic [31:0] w;
        w = 32'(s) * 32'h9E37_79B1;
        return {w, 32'(s) + 32'h0000_1234, ~w, 32'(s) ^ 32'h5A5A_5A5A};
    endfunction

    task automatic step(input bit v, input logic [1:0] op, input logic [4:0] dev,
                        input logic [4:0] bank, input logic [5:0] col,
                        input logic [127:0] data, input logic [15:0] mask, input bit msk);
        bit own, allow, load, exp_ret, exp_buf;
        string rtag, btag;
        logic [15:0] nmask;
        @(negedge clk);
        col_valid = v; col_op = op; col_dev = dev; col_bank = bank;
        col_addr = col; wr_data = data; wr_mask = mask; wr_masked = msk;
        own   = (dev == OWN);
        allow = v && !(own && op == 2'b01);
        load  = v && own && op == 2'b10;
        exp_ret = mv && allow;
        exp_buf = load ? 1'b1 : (exp_ret ? 1'b0 : mv);
        nmask = msk ? mask : 16'hFFFF;
        if (exp_ret) begin
            if (!own)             rtag = "R4";
            else if (op == 2'b10) rtag = "R7";
            else if (op == 2'b11) rtag = "R12";
            else                  rtag = "R5";
        end else begin
            if (!v)       rtag = "R8";
            else if (!mv) rtag = "R10";
            else          rtag = "R6";
        end
        if (load)            btag = "R2";
        else if (!mv && v && op == 2'b10) btag = "R9";
        else                 btag = rtag;
        @(posedge clk);
        #1;
        check(ret_valid == exp_ret, rtag, 128'(ret_valid), 128'(exp_ret));
        check(buf_valid == exp_buf, btag, 128'(buf_valid), 128'(exp_buf));
        if (exp_ret) begin
            lb = mb; lc = mc; ld = md; lm = mm;
            check(ret_data == md && ret_bank == mb && ret_addr == mc, rtag, ret_data, md);
            check(ret_mask == mm, "R3", 128'(ret_mask), 128'(mm));
        end else begin
            check(ret_data == ld && ret_bank == lb && ret_addr == lc && ret_mask == lm,
                  "R11", ret_data, ld);
        end
        if (load) begin
            mb = bank; mc = col; md = data; mm = nmask;
        end
        mv = exp_buf;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        n = 1;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(buf_valid == 1'b0 && ret_valid == 1'b0, "R1", 128'({buf_valid, ret_valid}), 128'(0));
        check(ret_data == '0 && ret_mask == '0, "R11", ret_data, 128'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // sweep: prior state x op x target x mask flag
        for (int pre = 0; pre < 2; pre++) begin
            for (int op = 0; op < 4; op++) begin
                for (int tgt = 0; tgt < 2; tgt++) begin
                    for (int mk = 0; mk < 2; mk++) begin
                        logic [4:0] dv;
                        dv = tgt ? OWN : (OWN ^ 5'(op + 1));
                        if (pre == 1)
                            step(1, 2'b10, OWN, 5'(n), 6'(n * 3), mkdata(n), 16'(n * 16'h0F1D), 1'(n & 1));
                        else
                            step(1, 2'b00, OWN ^ 5'h1, '0, '0, '0, '0, 0);
                        n++;
                        step(1, 2'(op), dv, 5'(n), 6'(n * 5), mkdata(n), 16'(n * 16'h3C5B), 1'(mk));
                        n++;
                        step(0, 2'b00, OWN, '0, '0, '0, '0, 0);
                        step(1, 2'b00, OWN, '0, '0, '0, '0, 0);
                    end
                end
            end
        end

        // repeated own reads stall the entry, then a no-op drains it
        step(1, 2'b10, OWN, 5'h1F, 6'h3F, {4{32'hDEAD_BEEF}}, 16'h8001, 1);
        for (int k = 0; k < 4; k++) step(1, 2'b01, OWN, '0, '0, '0, '0, 0);
        step(1, 2'b00, OWN, '0, '0, '0, '0, 0);

        // back-to-back own writes swap every cycle
        for (int k = 0; k < 8; k++)
            step(1, 2'b10, OWN, 5'(k), 6'(k + 40), mkdata(k + 900), 16'(1 << k), 1'(k & 1));

        // pseudo-random mix
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] op;
            logic [4:0] dv;
            seed = seed * 32'd1103515245 + 32'd12345;
            op = seed[17:16];
            dv = seed[20] ? OWN : 5'(seed[25:21]);
            step(seed[30] | seed[29], op, dv, seed[12:8], seed[7:2], mkdata(int'(seed)), seed[31:16], seed[19]);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule